// File: doc/BRIEF.md
# Iterative Signed/Unsigned Integer Divider

This block divides a 32-bit dividend by a 32-bit divisor over several cycles. It works in unsigned mode or in two's-complement signed mode. The quotient appears on the `lo` output and the remainder on the `hi` output. A single pulse on `start` captures both operands and the mode bit. The block then performs one shift, trial subtraction and restore step per clock. When the result registers hold the new answer, `done` pulses for one cycle.

In signed mode the operands are first reduced to magnitudes. The magnitudes go through the restoring loop, and the signs are put back in one final cycle. The quotient is truncated toward zero. The remainder carries the sign of the dividend, so that dividend = quotient × divisor + remainder always holds modulo 2^32.

A zero divisor and the signed most-negative ÷ −1 case never stall or trap. A zero divisor is reported on a flag that travels with the result.

Top module: `seq_divider`

## Requirements
- R1: While `rst` is high and on the first cycle after it falls, `busy`, `done`, `div_zero`, `hi` and `lo` are all zero.
- R2: A `start` seen while `busy` is high is ignored. The running operation finishes with the result of the operands captured when it began.
- R3: A `start` sampled while idle raises `busy` at that same edge. `busy` stays high for exactly W+1 cycles (W = 32 is the operand width). It falls at the edge where `done` rises, and `done` is high for exactly one cycle.
- R4: In unsigned mode (`is_signed` = 0) with a nonzero divisor, `lo` equals floor(dividend / divisor) and `hi` equals dividend mod divisor, both taken as unsigned.
- R5: In signed mode (`is_signed` = 1) with a nonzero divisor, `lo` is the quotient truncated toward zero. It is negative exactly when the operand signs differ. Example: 7 ÷ −2 gives −3.
- R6: In signed mode the remainder in `hi` has the sign of the dividend, or is zero. Examples: 7 ÷ −2 leaves 1, and −7 ÷ 2 leaves −1.
- R7: A zero divisor sets `div_zero` = 1 and gives `lo` = all ones and `hi` = the dividend as supplied, in either mode. `done` still pulses with the same timing as in R3.
- R8: Signed 0x80000000 ÷ 0xFFFFFFFF gives `lo` = 0x80000000, `hi` = 0 and `div_zero` = 0, with no other indication.
- R9: `hi`, `lo` and `div_zero` change only at the edge that raises `done`. They hold their values at every other time.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begin a division when idle |
| is_signed | input | 1 | 1 = two's-complement operands, 0 = unsigned |
| dividend | input | 32 | Numerator, sampled with `start` |
| divisor | input | 32 | Denominator, sampled with `start` |
| busy | output | 1 | High while an operation is in progress |
| done | output | 1 | One-cycle pulse when `hi`/`lo` are valid |
| div_zero | output | 1 | Divisor of the last result was zero |
| hi | output | 32 | Remainder of the last operation |
| lo | output | 32 | Quotient of the last operation |

## Verification
The bench aims at the four sign combinations with odd magnitudes. A design that picked the remainder sign from the divisor, or that rounded toward minus infinity, would give 7 ÷ −2 a remainder of −1 or a quotient of −4.

It divides by zero in both modes. A design that applied sign correction after a zero divisor would return a negated dividend or a quotient of 1.

It runs the most-negative ÷ −1 case and operands near the full unsigned range. These expose a remainder register missing its extra top bit, which would produce wrong quotient bits once the partial remainder exceeds 2^31. It also pulses `start` in the middle of an operation, so that a design which restarts or re-latches operands would show different results or a longer `busy`.

// File: rtl/div_pkg.sv
package div_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_FIX  = 2'd2
  } div_state_t;
endpackage

// File: rtl/div_operand_prep.sv
module div_operand_prep #(
  parameter int W = 32
) (
  input  logic         is_signed,
  input  logic [W-1:0] dvd_in,
  input  logic [W-1:0] dvs_in,
  output logic [W-1:0] dvd_mag,
  output logic [W-1:0] dvs_mag,
  output logic         neg_quo,
  output logic         neg_rem,
  output logic         dvs_zero
);
  logic dvd_neg, dvs_neg;

  always_comb begin
    dvd_neg  = is_signed & dvd_in[W-1];
    dvs_neg  = is_signed & dvs_in[W-1];
    dvd_mag  = dvd_neg ? (~dvd_in + 1'b1) : dvd_in;
    dvs_mag  = dvs_neg ? (~dvs_in + 1'b1) : dvs_in;
    neg_quo  = dvd_neg ^ dvs_neg;
    neg_rem  = dvd_neg;
    dvs_zero = (dvs_in == '0);
  end
endmodule

// File: rtl/div_restore_core.sv
module div_restore_core #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic         step,
  input  logic [W-1:0] dvd_mag,
  input  logic [W-1:0] dvs_mag,
  output logic [W-1:0] quo_mag,
  output logic [W-1:0] rem_mag
);
  localparam int RW = 2 * W + 1;

  logic [RW-1:0] part_q;
  logic [W-1:0]  dvs_q;
  logic [RW-1:0] shifted;
  logic [W+1:0]  trial;
  logic          fits;

  always_comb begin
    shifted = {part_q[RW-2:0], 1'b0};
    trial   = {1'b0, shifted[RW-1:W]} - {2'b00, dvs_q};
    fits    = ~trial[W+1];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      part_q <= '0;
      dvs_q  <= '0;
    end else if (load) begin
      part_q <= {{(W+1){1'b0}}, dvd_mag};
      dvs_q  <= dvs_mag;
    end else if (step) begin
      if (fits)
        part_q <= {trial[W:0], shifted[W-1:1], 1'b1};
      else
        part_q <= shifted;
    end
  end

  assign quo_mag = part_q[W-1:0];
  assign rem_mag = part_q[2*W-1:W];

  // R4
  partial_bound_chk: assert property (@(posedge clk) disable iff (rst)
    (step && dvs_q != '0) |=> (part_q[2*W-1:W] < dvs_q) && !part_q[RW-1]);
endmodule

// File: rtl/div_result_fix.sv
module div_result_fix #(
  parameter int W = 32
) (
  input  logic [W-1:0] quo_mag,
  input  logic [W-1:0] rem_mag,
  input  logic         neg_quo,
  input  logic         neg_rem,
  input  logic         dvs_zero,
  input  logic [W-1:0] dvd_raw,
  output logic [W-1:0] quo_out,
  output logic [W-1:0] rem_out
);
  always_comb begin
    if (dvs_zero) begin
      quo_out = '1;
      rem_out = dvd_raw;
    end else begin
      quo_out = neg_quo ? (~quo_mag + 1'b1) : quo_mag;
      rem_out = neg_rem ? (~rem_mag + 1'b1) : rem_mag;
    end
  end
endmodule

// File: rtl/seq_divider.sv
module seq_divider #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start,
  input  logic         is_signed,
  input  logic [W-1:0] dividend,
  input  logic [W-1:0] divisor,
  output logic         busy,
  output logic         done,
  output logic         div_zero,
  output logic [W-1:0] hi,
  output logic [W-1:0] lo
);
  import div_pkg::*;

  localparam int CW = $clog2(W + 1);
  localparam logic [CW-1:0] LAST = CW'(W - 1);

  div_state_t    state;
  logic [CW-1:0] step_cnt;
  logic          load, step;
  logic [W-1:0]  dvd_mag, dvs_mag, quo_mag, rem_mag, quo_fix, rem_fix;
  logic          neg_quo_c, neg_rem_c, zero_c;
  logic          neg_quo_q, neg_rem_q, zero_q;
  logic [W-1:0]  dvd_raw_q;

  assign load = (state == ST_IDLE) && start;
  assign step = (state == ST_RUN);

  div_operand_prep #(.W(W)) u_prep (
    .is_signed (is_signed),
    .dvd_in    (dividend),
    .dvs_in    (divisor),
    .dvd_mag   (dvd_mag),
    .dvs_mag   (dvs_mag),
    .neg_quo   (neg_quo_c),
    .neg_rem   (neg_rem_c),
    .dvs_zero  (zero_c)
  );

  div_restore_core #(.W(W)) u_core (
    .clk     (clk),
    .rst     (rst),
    .load    (load),
    .step    (step),
    .dvd_mag (dvd_mag),
    .dvs_mag (dvs_mag),
    .quo_mag (quo_mag),
    .rem_mag (rem_mag)
  );

  div_result_fix #(.W(W)) u_fix (
    .quo_mag  (quo_mag),
    .rem_mag  (rem_mag),
    .neg_quo  (neg_quo_q),
    .neg_rem  (neg_rem_q),
    .dvs_zero (zero_q),
    .dvd_raw  (dvd_raw_q),
    .quo_out  (quo_fix),
    .rem_out  (rem_fix)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      step_cnt  <= '0;
      busy      <= 1'b0;
      done      <= 1'b0;
      div_zero  <= 1'b0;
      hi        <= '0;
      lo        <= '0;
      neg_quo_q <= 1'b0;
      neg_rem_q <= 1'b0;
      zero_q    <= 1'b0;
      dvd_raw_q <= '0;
    end else begin
      done <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (start) begin
            state     <= ST_RUN;
            step_cnt  <= '0;
            busy      <= 1'b1;
            neg_quo_q <= neg_quo_c;
            neg_rem_q <= neg_rem_c;
            zero_q    <= zero_c;
            dvd_raw_q <= dividend;
          end
        end
        ST_RUN: begin
          step_cnt <= step_cnt + 1'b1;
          if (step_cnt == LAST) state <= ST_FIX;
        end
        ST_FIX: begin
          hi       <= rem_fix;
          lo       <= quo_fix;
          div_zero <= zero_q;
          done     <= 1'b1;
          busy     <= 1'b0;
          state    <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // Checker-only counter of busy cycles
  logic [CW:0] busy_len;
  always_ff @(posedge clk) begin
    if (rst)       busy_len <= '0;
    else if (busy) busy_len <= busy_len + 1'b1;
    else           busy_len <= '0;
  end

  // R3
  busy_len_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> busy_len == (CW+1)'(W + 1));

  // R3
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R3
  done_edge_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy && $past(busy));

  // R9
  result_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !done |-> $stable(hi) && $stable(lo) && $stable(div_zero));

  // R7
  zero_quo_chk: assert property (@(posedge clk) disable iff (rst)
    (done && div_zero) |-> lo == '1);
endmodule

// File: tb/seq_divider_test.sv
module seq_divider_test;
  localparam int W = 32;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         start = 1'b0;
  logic         is_signed = 1'b0;
  logic [W-1:0] dividend = '0;
  logic [W-1:0] divisor = '0;
  logic         busy, done, div_zero;
  logic [W-1:0] hi, lo;

  int total = 0;
  int bad = 0;
  int cycles = 0;

  seq_divider #(.W(W)) uut (
    .clk(clk), .rst(rst), .start(start), .is_signed(is_signed),
    .dividend(dividend), .divisor(divisor),
    .busy(busy), .done(done), .div_zero(div_zero), .hi(hi), .lo(lo)
  );

  always #2 clk = ~clk;

  // Reference model state
  logic         m_busy = 0, m_done = 0, m_dz = 0;
  logic [W-1:0] m_hi = '0, m_lo = '0;
  logic [W-1:0] p_hi, p_lo;
  logic         p_dz;
  int           m_cnt = 0;
  string        p_tag_lo = "R4", p_tag_hi = "R4";
  string        tag_lo = "R1", tag_hi = "R1";
  bit           ignored = 0;
  bit           compare_on = 0;

  task automatic ref_div(input logic sgn, input logic [W-1:0] a, input logic [W-1:0] b);
    longint sa, sb, q, r;
    if (b == '0) begin
      p_lo = '1; p_hi = a; p_dz = 1;
      p_tag_lo = "R7"; p_tag_hi = "R7";
    end else begin
      p_dz = 0;
      if (sgn) begin
        sa = longint'($signed(a)); sb = longint'($signed(b));
        p_tag_lo = "R5"; p_tag_hi = "R6";
        if (a == 32'h8000_0000 && b == '1) begin
          p_tag_lo = "R8"; p_tag_hi = "R8";
        end
      end else begin
        sa = longint'({32'h0, a}); sb = longint'({32'h0, b});
        p_tag_lo = "R4"; p_tag_hi = "R4";
      end
      q = sa / sb; r = sa % sb;
      p_lo = q[W-1:0]; p_hi = r[W-1:0];
    end
  endtask

  always @(posedge clk) begin
    if (rst) begin
      m_busy <= 0; m_done <= 0; m_dz <= 0; m_hi <= '0; m_lo <= '0; m_cnt <= 0;
    end else begin
      m_done <= 0;
      if (m_busy) begin
        if (start) ignored = 1;
        if (m_cnt == 1) begin
          m_busy <= 0; m_done <= 1; m_hi <= p_hi; m_lo <= p_lo; m_dz <= p_dz;
          tag_lo = ignored ? "R2" : p_tag_lo;
          tag_hi = ignored ? "R2" : p_tag_hi;
          ignored = 0;
        end
        m_cnt <= m_cnt - 1;
      end else if (start) begin
        ref_div(is_signed, dividend, divisor);
        m_busy <= 1; m_cnt <= W + 1;
      end
    end
  end

  task automatic check(input string tag, input string what, input logic [W-1:0] act, input logic [W-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h at cycle %0d", tag, what, act, exp, cycles);
    end
  endtask

  always @(negedge clk) begin
    cycles++;
    if (compare_on) begin
      check("R3", "busy", W'(busy), W'(m_busy));
      check("R3", "done", W'(done), W'(m_done));
      check(m_done ? "R7" : "R9", "div_zero", W'(div_zero), W'(m_dz));
      check(m_done ? tag_lo : "R9", "lo", lo, m_lo);
      check(m_done ? tag_hi : "R9", "hi", hi, m_hi);
    end
    if (cycles > 100000) begin
      bad++; total++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic run_div(input logic sgn, input logic [W-1:0] a, input logic [W-1:0] b);
    @(negedge clk);
    start = 1; is_signed = sgn; dividend = a; divisor = b;
    @(negedge clk);
    start = 0;
    repeat (W + 3) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset values
    check("R1", "busy", W'(busy), '0);
    check("R1", "done", W'(done), '0);
    check("R1", "div_zero", W'(div_zero), '0);
    check("R1", "hi", hi, '0);
    check("R1", "lo", lo, '0);
    rst = 0;
    @(negedge clk);
    check("R1", "lo after reset", lo, '0);
    compare_on = 1;

    run_div(0, 32'd100, 32'd7);
    run_div(0, 32'hFFFF_FFFF, 32'h0000_0003);
    run_div(0, 32'hFFFF_FFFE, 32'hFFFF_FFFF);
    run_div(0, 32'h8000_0001, 32'h8000_0000);
    run_div(0, 32'd5, 32'd9);
    run_div(1, 32'd7, -32'sd2);
    run_div(1, -32'sd7, 32'd2);
    run_div(1, -32'sd7, -32'sd2);
    run_div(1, 32'd7, 32'd2);
    run_div(1, 32'h8000_0000, 32'hFFFF_FFFF);
    run_div(1, 32'h8000_0000, 32'd3);
    run_div(0, 32'h1234_5678, 32'd0);
    run_div(1, -32'sd9, 32'd0);

    // R2: start pulsed mid-operation with other operands
    @(negedge clk);
    start = 1; is_signed = 0; dividend = 32'd1000; divisor = 32'd33;
    @(negedge clk);
    start = 0;
    repeat (10) @(negedge clk);
    start = 1; dividend = 32'd5; divisor = 32'd0;
    @(negedge clk);
    start = 0;
    repeat (W + 3) @(negedge clk);

    // R9: idle cycles with changing inputs, no start
    dividend = 32'hDEAD_BEEF; divisor = 32'd1; is_signed = 1;
    repeat (5) @(negedge clk);

    compare_on = 0;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule